// File: doc/BRIEF.md
# Multi-Input Wakeup Edge Detector

This block monitors a bank of general-purpose input pins and records a programmable edge on each one as a sticky pending flag. Each channel can be armed on its own and set to catch either a rising or a falling transition. The OR of all pending flags forms a wakeup request. When the interrupt-enable control bit is set, the same OR also drives a shared interrupt line. Software reaches the three per-pin registers and one control register through a simple single-cycle register bus. The pending register can only be cleared from software, so a hardware edge that arrives during a clear write is never lost.

Each pin is resynchronised with a two-flop chain before the edge compare. One channel can take an internal PWM-off level as its source instead of its pin, under a control-register select bit. A small power-state machine accepts or refuses a stop/idle request. It refuses while any flag is pending, and it returns to the awake state as soon as a flag appears.

Top module: `wake_edge_ctrl`

## Requirements
- R1: After reset, every register reads 0x00, and `wake_req`, `irq`, `asleep` and `sleep_nak` are 0.
- R2: A rising edge on an armed pin whose polarity bit is 0 sets that pin's pending bit. The bit reads as 1 after the third rising clock edge that follows the pin change.
- R3: A falling edge on an armed pin whose polarity bit is 1 sets that pin's pending bit. An edge of the opposite sense has no effect.
- R4: A pin whose arm bit is 0 never sets its pending bit, whatever edges it sees.
- R5: In a write to the pending register (address 2), each data bit of 0 clears the matching flag and each data bit of 1 leaves it unchanged. Writing 0xF7 clears only bit 3, and no write can set a flag.
- R6: If a detected edge and a software clear reach the same pending bit on the same clock edge, the bit ends up set.
- R7: `wake_req` is the OR of all pending bits. `irq` equals `wake_req` when control bit 0 (interrupt enable) is 1, and is 0 otherwise.
- R8: When control bit 1 (source select) is 1, `pwm_off` replaces pin 6 as the source of channel 6, and pin 6 is then ignored.
- R9: A `sleep_req` made while awake with any flag pending is refused. `sleep_nak` pulses high for one cycle on the next clock, and `asleep` stays 0.
- R10: A `sleep_req` made while awake with no flag pending sets `asleep` on the next clock. While asleep, a pending flag clears `asleep` on the next clock.
- R11: The register map is: address 0 holds the arm bits, 1 the polarity bits, 2 the pending flags, and 3 the control bits. Unused control bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | Asynchronous general-purpose pin levels |
| pwm_off | input | 1 | Internal PWM-off level, alternate source for channel 6 |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | NUM_PINS | Write data |
| bus_rdata | output | NUM_PINS | Read data for `bus_addr`, combinational |
| sleep_req | input | 1 | Request to enter the low-power state |
| sleep_nak | output | 1 | One-cycle refusal of a request |
| asleep | output | 1 | Low-power state is active |
| wake_req | output | 1 | OR of all pending flags |
| irq | output | 1 | Shared interrupt, gated by interrupt enable |

## Verification
The bench sets up a clear write that lands on the same clock edge as a detected edge. A design where the clear wins would lose that wakeup. It writes 0xF7 and 0xFF over a full pending register, which exposes a design that writes the data straight into the flags or that lets a 1 set a flag. It toggles pin 6 while the PWM-off source is selected, and it toggles pins whose arm bit is 0. A wrong source mux or a missing arm gate would raise spurious flags there. Sleep requests are issued both with and without flags pending, against a cycle model that catches an accepted request that should have been refused.

// File: rtl/wake_pkg.sv
`timescale 1ns/1ps
package wake_pkg;
    localparam int unsigned REG_ADDR_W = 2;

    localparam logic [REG_ADDR_W-1:0] RA_ARM  = 2'd0;
    localparam logic [REG_ADDR_W-1:0] RA_POL  = 2'd1;
    localparam logic [REG_ADDR_W-1:0] RA_PEND = 2'd2;
    localparam logic [REG_ADDR_W-1:0] RA_CTRL = 2'd3;

    localparam int unsigned CTRL_IE  = 0;
    localparam int unsigned CTRL_SEL = 1;

    typedef enum logic {
        PS_AWAKE  = 1'b0,
        PS_ASLEEP = 1'b1
    } pwr_state_e;
endpackage

// File: rtl/wake_sync.sv
`timescale 1ns/1ps
module wake_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wake_edge_chan.sv
`timescale 1ns/1ps
module wake_edge_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic arm,
    input  logic pol_fall,
    input  logic sw_clr,
    output logic hit,
    output logic pend
);
    logic prev_q;
    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    always_comb begin
        if (pol_fall) hit = arm & prev_q & ~lvl;
        else          hit = arm & ~prev_q & lvl;
    end

    // A set on the same edge as a clear wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= hit | (pend_q & ~sw_clr);
    end

    assign pend = pend_q;
endmodule

// File: rtl/wake_regbank.sv
`timescale 1ns/1ps
module wake_regbank
    import wake_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr,
    input  logic [N-1:0]          bus_wdata,
    input  logic [N-1:0]          pend,
    output logic [N-1:0]          arm_q,
    output logic [N-1:0]          pol_q,
    output logic                  int_en,
    output logic                  src_sel,
    output logic [N-1:0]          pend_clr,
    output logic [N-1:0]          bus_rdata
);
    logic [N-1:0] ctrl_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q   <= '0;
            pol_q   <= '0;
            int_en  <= 1'b0;
            src_sel <= 1'b0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                RA_ARM:  arm_q <= bus_wdata;
                RA_POL:  pol_q <= bus_wdata;
                RA_CTRL: begin
                    int_en  <= bus_wdata[CTRL_IE];
                    src_sel <= bus_wdata[CTRL_SEL];
                end
                default: ;
            endcase
        end
    end

    assign pend_clr = (bus_wr && bus_addr == RA_PEND) ? ~bus_wdata : '0;

    always_comb begin
        ctrl_rd           = '0;
        ctrl_rd[CTRL_IE]  = int_en;
        ctrl_rd[CTRL_SEL] = src_sel;
    end

    always_comb begin
        unique case (bus_addr)
            RA_ARM:  bus_rdata = arm_q;
            RA_POL:  bus_rdata = pol_q;
            RA_PEND: bus_rdata = pend;
            default: bus_rdata = ctrl_rd;
        endcase
    end
endmodule

// File: rtl/wake_sleep_fsm.sv
`timescale 1ns/1ps
module wake_sleep_fsm
    import wake_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_pend,
    input  logic sleep_req,
    output logic asleep,
    output logic sleep_nak
);
    pwr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_AWAKE:  if (sleep_req && !any_pend) state_d = PS_ASLEEP;
            PS_ASLEEP: if (any_pend)               state_d = PS_AWAKE;
            default:                               state_d = PS_AWAKE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_AWAKE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sleep_nak <= 1'b0;
        else        sleep_nak <= (state_q == PS_AWAKE) && sleep_req && any_pend;
    end

    assign asleep = (state_q == PS_ASLEEP);
endmodule

// File: rtl/wake_edge_ctrl.sv
`timescale 1ns/1ps
module wake_edge_ctrl
    import wake_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ALT_CHAN    = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_in,
    input  logic                  pwm_off,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr,
    input  logic [NUM_PINS-1:0]   bus_wdata,
    output logic [NUM_PINS-1:0]   bus_rdata,
    input  logic                  sleep_req,
    output logic                  sleep_nak,
    output logic                  asleep,
    output logic                  wake_req,
    output logic                  irq
);
    logic [NUM_PINS-1:0] wk_src;
    logic [NUM_PINS-1:0] wk_sync;
    logic [NUM_PINS-1:0] wk_arm;
    logic [NUM_PINS-1:0] wk_pol;
    logic [NUM_PINS-1:0] wk_clr;
    logic [NUM_PINS-1:0] wk_hit;
    logic [NUM_PINS-1:0] wk_pend;
    logic                wk_ie;
    logic                wk_sel;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_src
        if (i == ALT_CHAN) begin : g_alt
            assign wk_src[i] = wk_sel ? pwm_off : pin_in[i];
        end else begin : g_pin
            assign wk_src[i] = pin_in[i];
        end
    end

    wake_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (wk_src),
        .q     (wk_sync)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chan
        wake_edge_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl      (wk_sync[i]),
            .arm      (wk_arm[i]),
            .pol_fall (wk_pol[i]),
            .sw_clr   (wk_clr[i]),
            .hit      (wk_hit[i]),
            .pend     (wk_pend[i])
        );
    end

    wake_regbank #(.N(NUM_PINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .pend      (wk_pend),
        .arm_q     (wk_arm),
        .pol_q     (wk_pol),
        .int_en    (wk_ie),
        .src_sel   (wk_sel),
        .pend_clr  (wk_clr),
        .bus_rdata (bus_rdata)
    );

    assign wake_req = |wk_pend;
    assign irq      = wk_ie & wake_req;

    wake_sleep_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_pend  (wake_req),
        .sleep_req (sleep_req),
        .asleep    (asleep),
        .sleep_nak (sleep_nak)
    );
endmodule

// File: rtl/wake_edge_ctrl_chk.sv
`timescale 1ns/1ps
module wake_edge_ctrl_chk #(
    parameter int unsigned N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wake_req,
    input logic         irq,
    input logic         asleep,
    input logic         sleep_req,
    input logic         sleep_nak,
    input logic [N-1:0] arm_q,
    input logic [N-1:0] pend_q
);
    a_r4_set_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & ~$past(pend_q) & ~$past(arm_q)) == '0);

    a_r7_irq_implies_wake: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> wake_req);

    a_r9_nak_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_nak |-> $past(sleep_req && wake_req && !asleep));

    a_r9_nak_stays_awake: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_nak |-> !asleep);

    a_r10_enter_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && !wake_req && !asleep) |=> asleep);

    a_r10_wake_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && wake_req) |=> !asleep);
endmodule

bind wake_edge_ctrl wake_edge_ctrl_chk #(.N(NUM_PINS)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wake_req  (wake_req),
    .irq       (irq),
    .asleep    (asleep),
    .sleep_req (sleep_req),
    .sleep_nak (sleep_nak),
    .arm_q     (wk_arm),
    .pend_q    (wk_pend)
);

// File: tb/test_wake_edge_ctrl.sv
`timescale 1ns/1ps
module test_wake_edge_ctrl;
    import wake_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_in = '0;
    logic       pwm_off = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sleep_req = 1'b0;
    logic       sleep_nak, asleep, wake_req, irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0] pins_v = '0;
    logic       pwm_v = 1'b0;

    // cycle model built from the requirements
    logic [7:0] m_arm, m_pol, m_s1, m_s2, m_prev, m_pend;
    logic       m_ie, m_sel, m_asleep, m_nak;

    always #4 clk = ~clk;

    wake_edge_ctrl i_wake_edge_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pwm_off(pwm_off),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .sleep_req(sleep_req), .sleep_nak(sleep_nak),
        .asleep(asleep), .wake_req(wake_req), .irq(irq)
    );

    always @(posedge clk) begin
        logic [7:0] src, hit, clr;
        if (!rst_n) begin
            m_arm <= '0; m_pol <= '0; m_s1 <= '0; m_s2 <= '0; m_prev <= '0;
            m_pend <= '0; m_ie <= 0; m_sel <= 0; m_asleep <= 0; m_nak <= 0;
        end else begin
            src = pin_in;
            if (m_sel) src[6] = pwm_off;
            hit = m_arm & ((m_pol & m_prev & ~m_s2) | (~m_pol & ~m_prev & m_s2));
            clr = (bus_wr && bus_addr == RA_PEND) ? ~bus_wdata : 8'h00;
            m_s1 <= src; m_s2 <= m_s1; m_prev <= m_s2;
            m_pend <= hit | (m_pend & ~clr);
            if (bus_wr && bus_addr == RA_ARM) m_arm <= bus_wdata;
            if (bus_wr && bus_addr == RA_POL) m_pol <= bus_wdata;
            if (bus_wr && bus_addr == RA_CTRL) begin
                m_ie <= bus_wdata[0]; m_sel <= bus_wdata[1];
            end
            m_nak <= !m_asleep && sleep_req && (|m_pend);
            if (!m_asleep) m_asleep <= sleep_req && !(|m_pend);
            else           m_asleep <= !(|m_pend);
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        bus_wr = 1'b0; bus_addr = a; #1; v = bus_rdata;
    endtask

    task automatic cyc(input logic w, input logic [1:0] a, input logic [7:0] d, input logic sr);
        logic [7:0] v;
        @(negedge clk);
        pin_in = pins_v; pwm_off = pwm_v; bus_wr = w; bus_addr = a;
        bus_wdata = d; sleep_req = sr;
        @(posedge clk); #1;
        chk("R7 wake_req", {7'd0, wake_req}, {7'd0, |m_pend});
        chk("R7 irq", {7'd0, irq}, {7'd0, m_ie & (|m_pend)});
        chk("R10 asleep", {7'd0, asleep}, {7'd0, m_asleep});
        chk("R9 sleep_nak", {7'd0, sleep_nak}, {7'd0, m_nak});
        rd(RA_PEND, v);
        chk("R2 pending model", v, m_pend);
        sleep_req = 1'b0;
    endtask

    task automatic tick(); cyc(1'b0, RA_ARM, 8'h00, 1'b0); endtask
    task automatic wr(input logic [1:0] a, input logic [7:0] d); cyc(1'b1, a, d, 1'b0); endtask
    task automatic ticks(input int n); for (int k = 0; k < n; k++) tick(); endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd4242));
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state, R11 map
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v); chk("R1 reset reg", v, 8'h00);
        end
        chk("R1 outputs", {4'd0, wake_req, irq, asleep, sleep_nak}, 8'h00);

        // R11 register map readback
        wr(RA_ARM, 8'hFF); wr(RA_POL, 8'h00); wr(RA_CTRL, 8'hFF);
        rd(RA_ARM, v);  chk("R11 arm", v, 8'hFF);
        rd(RA_POL, v);  chk("R11 pol", v, 8'h00);
        rd(RA_CTRL, v); chk("R11 ctrl upper bits zero", v, 8'h03);
        wr(RA_CTRL, 8'h01);

        // R2 rising-edge latency
        pins_v[0] = 1'b1;
        tick(); tick();
        rd(RA_PEND, v); chk("R2 not yet after two edges", v, 8'h00);
        tick();
        rd(RA_PEND, v); chk("R2 rising sets bit0", v, 8'h01);
        chk("R7 irq with ie", {7'd0, irq}, 8'h01);
        wr(RA_PEND, 8'h00);

        // R3 falling detection, opposite sense ignored
        wr(RA_POL, 8'h02);
        pins_v[1] = 1'b1; ticks(4);
        rd(RA_PEND, v); chk("R3 rising ignored when falling selected", v, 8'h00);
        pins_v[1] = 1'b0; ticks(3);
        rd(RA_PEND, v); chk("R3 falling sets bit1", v, 8'h02);
        wr(RA_PEND, 8'h00); wr(RA_POL, 8'h00);

        // R4 disarmed pin
        wr(RA_ARM, 8'hFE);
        pins_v[0] = 1'b0; ticks(3); pins_v[0] = 1'b1; ticks(4);
        rd(RA_PEND, v); chk("R4 disarmed pin sets nothing", v, 8'h00);
        wr(RA_ARM, 8'hFF);

        // R5 clear-only write
        pins_v = 8'h00; ticks(4);
        wr(RA_PEND, 8'h00);
        pins_v = 8'hFF; ticks(4);
        rd(RA_PEND, v); chk("R5 all flags set", v, 8'hFF);
        wr(RA_PEND, 8'hF7);
        rd(RA_PEND, v); chk("R5 0xF7 clears bit3 only", v, 8'hF7);
        wr(RA_PEND, 8'hFF);
        rd(RA_PEND, v); chk("R5 ones preserve", v, 8'hF7);
        wr(RA_PEND, 8'h00); wr(RA_PEND, 8'hFF);
        rd(RA_PEND, v); chk("R5 write cannot set", v, 8'h00);

        // R6 set beats clear on the same edge
        pins_v[1] = 1'b0; ticks(4); wr(RA_PEND, 8'h00);
        pins_v[1] = 1'b1; tick(); tick();
        wr(RA_PEND, 8'hFD);
        rd(RA_PEND, v); chk("R6 set wins over clear", v, 8'h02);
        wr(RA_PEND, 8'hFD);
        rd(RA_PEND, v); chk("R6 later clear works", v, 8'h00);

        // R8 pwm_off substitutes pin 6
        pins_v = 8'h00; pwm_v = 1'b0; ticks(4); wr(RA_PEND, 8'h00);
        wr(RA_CTRL, 8'h03);
        pwm_v = 1'b1; ticks(3);
        rd(RA_PEND, v); chk("R8 pwm_off sets bit6", v, 8'h40);
        wr(RA_PEND, 8'h00);
        pins_v[6] = 1'b1; ticks(4); pins_v[6] = 1'b0; ticks(2);
        rd(RA_PEND, v); chk("R8 pin6 ignored when selected", v, 8'h00);
        pwm_v = 1'b0; ticks(3); wr(RA_CTRL, 8'h01);

        // R9 refusal while pending, R10 entry and exit
        pins_v[2] = 1'b1; ticks(3);
        cyc(1'b0, RA_ARM, 8'h00, 1'b1);
        chk("R9 nak pulse", {6'd0, sleep_nak, asleep}, 8'h02);
        tick();
        chk("R9 nak one cycle", {7'd0, sleep_nak}, 8'h00);
        wr(RA_PEND, 8'h00);
        cyc(1'b0, RA_ARM, 8'h00, 1'b1);
        chk("R10 asleep entered", {7'd0, asleep}, 8'h01);
        pins_v[3] = 1'b1; ticks(3);
        chk("R10 flag set", {7'd0, wake_req}, 8'h01);
        tick();
        chk("R10 woke on flag", {7'd0, asleep}, 8'h00);
        wr(RA_PEND, 8'h00);

        // random phase
        for (int i = 0; i < 600; i++) begin
            int unsigned op;
            pins_v = 8'($urandom);
            pwm_v = 1'($urandom);
            op = $urandom % 12;
            if (op < 3)       wr(RA_PEND, 8'($urandom));
            else if (op == 3) wr(RA_ARM, 8'($urandom));
            else if (op == 4) wr(RA_POL, 8'($urandom));
            else if (op == 5) wr(RA_CTRL, 8'($urandom));
            else if (op < 8)  cyc(1'b0, RA_ARM, 8'h00, 1'b1);
            else              tick();
        end

        done = 1;
        summary();
        $finish;
    end
endmodule